// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block makes the 16x oversampling tick that a UART receiver and transmitter use, starting from a fast reference clock. One bit time is split into sixteen sample slots. Each slot normally lasts `divisor + 1` reference clocks. In fractional mode a 16-bit slot mask can make any chosen slot one clock longer. A bit time is therefore `16*(divisor+1) + n` clocks, with `n` the number of set mask bits, which gives 1/16 resolution on the effective divisor.

Software loads the divisor and the mask through a one-cycle write strobe. The new values, and the mode input, are held in a shadow stage. They move into the active stage only when slot 15 ends, so no bit period mixes two settings. A combinational helper turns a 4-bit fractional remainder into the recommended evenly spread mask for software to use. For a reference rate `F` and baud rate `B`, the divisor is `(F/B)/16 - 1` and the remainder is `(F/B) mod 16`. A build without fractional capability keeps the mask at zero.

Top module: `frac_tick_gen`

## Requirements
- R1: Synchronous active-high reset clears the active divisor, active mask, mode, slot index and period counter. In the first cycle after reset, `tick` is 1 and `slot` is 0, and a tick then occurs on every reference clock.
- R2: With the latched mode at 0 (integer mode), every slot lasts exactly `divisor + 1` clocks, whatever the mask holds.
- R3: With the latched mode at 1, slot k lasts `divisor + 1 + mask[k]` clocks. Bit 0 of the mask belongs to slot 0.
- R4: Over the sixteen slots from slot 0 to slot 15, the total number of clocks is `16*(divisor+1) + popcount(effective mask)`.
- R5: `slot` shows the index of the slot being timed. It steps by one in the cycle after each tick, wraps from 15 to 0, and holds its value while there is no tick.
- R6: A write with `wr_en`=1 sets the shadow divisor (`wr_sel`=0, from `wr_data[15:0]`) or the shadow mask (`wr_sel`=1). The shadow divisor, the shadow mask and `frac_en` are copied into the active stage only on the tick that ends slot 15. Slots already in progress keep the old timing.
- R7: `rem_mask` gives the recommended mask for remainder `rem_in`. For remainders 0..15 the masks are 0000, 0080, 0808, 0888, 2222, 4924, 4A52, 54AA, 5555, D555, D5D5, DDD5, DDDD, DFDD, DFDF and FFDF, all in hex.
- R8: `rem_mask` has exactly `rem_in` bits set.
- R9: When the parameter `HAS_FRAC` is 0, mask writes are ignored and the active mask stays 0, so slots last `divisor + 1` clocks even with `frac_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_en | input | 1 | Mode request: 1 fractional, 0 integer; latched at slot-0 boundary |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 divisor, 1 slot mask |
| wr_data | input | 16 | Write value |
| rem_in | input | 4 | Fractional remainder for the mask helper |
| rem_mask | output | 16 | Recommended slot mask for `rem_in` |
| tick | output | 1 | Oversample tick, high in the last clock of each slot |
| slot | output | 4 | Index of the slot currently being timed |

## Verification
Each frame is measured slot by slot, under several patterns. The zero setting after reset shows the minimum period. Integer mode with a busy mask shows whether the mask is ignored. Random divisors with random masks separate per-slot stretching from errors in the bit position or the total. The recommended masks for every remainder check both the helper and the end-to-end fractional sum. A divisor written in the middle of a frame shows whether the update waits for the slot-0 boundary. A second instance built without fractional capability gets a full mask, to show that the mask has no effect there.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;

    localparam int unsigned DIV_W   = 16;
    localparam int unsigned WDATA_W = 16;
    localparam int unsigned SLOTS   = 16;
    localparam int unsigned SLOT_W  = $clog2(SLOTS);
    localparam int unsigned CNT_W   = DIV_W + 1;

    typedef enum logic {
        SEL_DIVISOR = 1'b0,
        SEL_MASK    = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SLOTS-1:0] mask;
        logic             frac;
    } baud_cfg_t;

    localparam baud_cfg_t CFG_RESET = '{div: '0, mask: '0, frac: 1'b0};

    // Evenly spread stretch pattern for a 1/16 remainder.
    function automatic logic [SLOTS-1:0] spread_mask(input logic [SLOT_W-1:0] rem);
        logic [SLOTS-1:0] m;
        unique case (rem)
            4'd0:  m = 16'h0000;
            4'd1:  m = 16'h0080;
            4'd2:  m = 16'h0808;
            4'd3:  m = 16'h0888;
            4'd4:  m = 16'h2222;
            4'd5:  m = 16'h4924;
            4'd6:  m = 16'h4A52;
            4'd7:  m = 16'h54AA;
            4'd8:  m = 16'h5555;
            4'd9:  m = 16'hD555;
            4'd10: m = 16'hD5D5;
            4'd11: m = 16'hDDD5;
            4'd12: m = 16'hDDDD;
            4'd13: m = 16'hDFDD;
            4'd14: m = 16'hDFDF;
            default: m = 16'hFFDF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/frac_tick_regs.sv
module frac_tick_regs
    import fbaud_pkg::*;
#(
    parameter bit HAS_FRAC = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               frac_en,
    input  logic               boundary,
    output baud_cfg_t          act
);

    logic [DIV_W-1:0] sh_div;
    logic [SLOTS-1:0] sh_mask;
    wr_target_e       target;

    assign target = wr_target_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_div <= '0;
        end else if (wr_en && target == SEL_DIVISOR) begin
            sh_div <= wr_data[DIV_W-1:0];
        end
    end

    generate
        if (HAS_FRAC) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_mask <= '0;
                end else if (wr_en && target == SEL_MASK) begin
                    sh_mask <= wr_data[SLOTS-1:0];
                end
            end
        end else begin : g_nomask
            assign sh_mask = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= CFG_RESET;
        end else if (boundary) begin
            act.div  <= sh_div;
            act.mask <= sh_mask;
            act.frac <= frac_en;
        end
    end

endmodule

// File: rtl/frac_tick_counter.sv
module frac_tick_counter
    import fbaud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  baud_cfg_t         act,
    output logic              tick,
    output logic [SLOT_W-1:0] slot
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             stretch;

    assign stretch = act.frac & act.mask[slot];
    assign limit   = {1'b0, act.div} + CNT_W'(stretch);
    assign tick    = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            slot <= '0;
        end else if (tick) begin
            cnt  <= '0;
            slot <= slot + SLOT_W'(1);
        end else begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/frac_mask_lut.sv
module frac_mask_lut
    import fbaud_pkg::*;
(
    input  logic [SLOT_W-1:0] rem,
    output logic [SLOTS-1:0]  mask
);

    always_comb mask = spread_mask(rem);

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
    import fbaud_pkg::*;
#(
    parameter bit HAS_FRAC = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frac_en,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [15:0]  wr_data,
    input  logic [3:0]   rem_in,
    output logic [15:0]  rem_mask,
    output logic         tick,
    output logic [3:0]   slot
);

    baud_cfg_t act;
    logic      boundary;

    assign boundary = tick && (slot == SLOT_W'(SLOTS - 1));

    frac_tick_regs #(.HAS_FRAC(HAS_FRAC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .frac_en  (frac_en),
        .boundary (boundary),
        .act      (act)
    );

    frac_tick_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .tick (tick),
        .slot (slot)
    );

    frac_mask_lut u_lut (
        .rem  (rem_in),
        .mask (rem_mask)
    );

endmodule

// File: rtl/frac_tick_chk.sv
module frac_tick_chk
    import fbaud_pkg::*;
#(
    parameter bit HAS_FRAC = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [SLOT_W-1:0] slot,
    input baud_cfg_t         act,
    input logic [SLOT_W-1:0] rem_in,
    input logic [SLOTS-1:0]  rem_mask
);

    logic [CNT_W-1:0] len;
    logic             ext;

    assign ext = act.frac & act.mask[slot];

    always_ff @(posedge clk) begin
        if (rst || tick) len <= '0;
        else             len <= len + CNT_W'(1);
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tick && slot == '0));

    assert_slot_len_R3: assert property (@(posedge clk) disable iff (rst)
        tick |-> (len == {1'b0, act.div} + CNT_W'(ext)));

    assert_slot_step_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> (slot == $past(slot) + SLOT_W'(1)));

    assert_slot_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slot));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(tick && slot == SLOT_W'(SLOTS - 1)) |=> $stable(act));

    assert_mask_count_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(rem_mask) == int'(rem_in));

    generate
        if (!HAS_FRAC) begin : g_nofrac
            assert_mask_zero_R9: assert property (@(posedge clk) disable iff (rst)
                act.mask == '0);
        end
    endgenerate

endmodule

bind frac_tick_gen frac_tick_chk #(.HAS_FRAC(HAS_FRAC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .slot     (slot),
    .act      (act),
    .rem_in   (rem_in),
    .rem_mask (rem_mask)
);

// File: tb/sim_frac_tick_gen.sv
module sim_frac_tick_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frac_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rem_in = '0;
    logic [15:0] rem_mask0, rem_mask1;
    logic        tick0, tick1;
    logic [3:0]  slot0, slot1;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_tick_gen #(.HAS_FRAC(1'b1)) u0 (
        .clk(clk), .rst(rst), .frac_en(frac_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rem_in(rem_in), .rem_mask(rem_mask0),
        .tick(tick0), .slot(slot0)
    );

    frac_tick_gen #(.HAS_FRAC(1'b0)) u1 (
        .clk(clk), .rst(rst), .frac_en(frac_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rem_in(rem_in), .rem_mask(rem_mask1),
        .tick(tick1), .slot(slot1)
    );

    function automatic logic [15:0] exp_mask(input int r);
        case (r)
            0: return 16'h0000;  1: return 16'h0080;  2: return 16'h0808;  3: return 16'h0888;
            4: return 16'h2222;  5: return 16'h4924;  6: return 16'h4A52;  7: return 16'h54AA;
            8: return 16'h5555;  9: return 16'hD555; 10: return 16'hD5D5; 11: return 16'hDDD5;
            12: return 16'hDDDD; 13: return 16'hDFDD; 14: return 16'hDFDF; default: return 16'hFFDF;
        endcase
    endfunction

    function automatic int popc(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic tick_of(input int inst);
        return (inst == 0) ? tick0 : tick1;
    endfunction

    function automatic int slot_of(input int inst);
        return (inst == 0) ? int'(slot0) : int'(slot1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_boundary(input int inst);
        do @(negedge clk); while (!(tick_of(inst) && slot_of(inst) == 15));
    endtask

    // Measure one whole frame after the next boundary and compare slot lengths.
    task automatic measure(input int inst, input int div, input logic [15:0] mask,
                           input bit frac, input string req);
        int sum = 0, bad_len = 0, bad_slot = 0, got_len = 0, want_len = 0, n;
        logic [15:0] eff;
        eff = frac ? mask : 16'h0;
        wait_boundary(inst);
        for (int k = 0; k < 16; k++) begin
            n = 0;
            do begin @(negedge clk); n++; end while (!tick_of(inst));
            if (slot_of(inst) != k) bad_slot++;
            if (n != div + 1 + int'(eff[k]) && bad_len == 0) begin
                got_len = n; want_len = div + 1 + int'(eff[k]);
            end
            if (n != div + 1 + int'(eff[k])) bad_len++;
            sum += n;
        end
        chk(bad_len == 0, req, "slot length", got_len, want_len);
        chk(bad_slot == 0, "R5", "slot index mismatches", bad_slot, 0);
        chk(sum == 16 * (div + 1) + popc(eff), "R4", "frame clocks", sum,
            16 * (div + 1) + popc(eff));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int d;
        logic [15:0] m;
        bit f;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state, first cycle after release
        chk(tick0 == 1'b1, "R1", "tick after reset", int'(tick0), 1);
        chk(slot0 == 4'd0, "R1", "slot after reset", int'(slot0), 0);
        @(negedge clk);
        chk(tick0 == 1'b1 && slot0 == 4'd1, "R1", "tick every clock, slot", int'(slot0), 1);
        measure(0, 0, 16'h0, 1'b0, "R1");

        // R7 / R8: helper table and bit counts
        for (int r = 0; r < 16; r++) begin
            rem_in = 4'(r);
            #1;
            chk(rem_mask0 == exp_mask(r), "R7", $sformatf("mask for rem %0d", r),
                int'(rem_mask0), int'(exp_mask(r)));
            chk(popc(rem_mask0) == r, "R8", "set bits", popc(rem_mask0), r);
        end

        // R2: integer mode ignores a busy mask
        frac_en = 1'b0;
        wr(1'b0, 16'd4);
        wr(1'b1, 16'hFFFF);
        measure(0, 4, 16'hFFFF, 1'b0, "R2");

        // R3: fractional mode, recommended masks
        frac_en = 1'b1;
        for (int r = 1; r < 16; r += 7) begin
            wr(1'b0, 16'(r % 3 + 1));
            wr(1'b1, exp_mask(r));
            measure(0, r % 3 + 1, exp_mask(r), 1'b1, "R3");
        end

        // R3: random divisor, mask and mode
        for (int it = 0; it < 12; it++) begin
            d = int'($urandom_range(0, 12));
            m = 16'($urandom);
            f = 1'($urandom);
            frac_en = f;
            wr(1'b0, 16'(d));
            wr(1'b1, m);
            measure(0, d, m, f, f ? "R3" : "R2");
        end

        // R6: divisor written mid-frame applies only from the next slot 0
        frac_en = 1'b1;
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'd2);
        wait_boundary(0);
        wait_boundary(0);
        do @(negedge clk); while (!(tick0 && slot0 == 4'd3));
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd5;
        begin
            int bad = 0, last = 0, n;
            for (int k = 4; k < 16; k++) begin
                n = 0;
                do begin @(negedge clk); wr_en = 1'b0; n++; end while (!tick0);
                if (n != 3) begin bad++; last = n; end
            end
            chk(bad == 0, "R6", "old period kept after mid-frame write", last, 3);
        end
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!tick0);
            chk(n == 6 && slot0 == 4'd0, "R6", "new period at slot 0", n, 6);
        end

        // R9: build without fractional capability ignores the mask
        frac_en = 1'b1;
        wr(1'b0, 16'd3);
        wr(1'b1, 16'hFFFF);
        measure(1, 3, 16'h0, 1'b1, "R9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule